// File: doc/BRIEF.md
# Level-to-Pulse Interrupt Combiner

This block takes four level-sensitive interrupt requests and merges them into one interrupt line that is pulsed for a single clock cycle. The requests come from a network MAC and its PHY management interface:

- a host event
- a statistics event
- a PHY link-change event
- a management-access-complete event

Each request can be masked on its own through an enable register. Software writes that register through a simple write/read port and can read it back.

Edges are detected on each source separately, after masking, and the results are ORed together. A source that rises while another enabled source is already high therefore still produces a fresh pulse, so the processor does not miss the event. Clearing the sources, and everything on the processor's interrupt-controller side, are handled elsewhere.

Top module: `irq_pulse_merge`

## Requirements
- R1: While reset is held, and on the first cycle after it, `irq_pulse` is 0 and `cfg_rdata` reads 0. This is true even if sources are high.
- R2: When `cfg_we` is 1 at a rising clock edge, bits 4:1 of `cfg_wdata` become the enables. The mapping is host = bit 1, statistics = bit 2, link = bit 3, access-done = bit 4. `src_level` uses the same order at bits 0 to 3. The stored enables read back at bits 4:1 of `cfg_rdata`.
- R3: `cfg_rdata` bit 0 and bits 31:5 always read 0, whatever was written there.
- R4: An enabled source that is sampled high at a clock edge, after being sampled low (or disabled) at the previous edge, drives `irq_pulse` to 1 for exactly the following cycle.
- R5: While the enabled levels stay unchanged, no further pulse is produced.
- R6: A source whose enable bit is 0 never causes a pulse.
- R7: A newly rising enabled source produces a pulse even when another enabled source is already high.
- R8: Setting the enable of a source that is already high counts as a rising edge. A pulse follows one cycle after the write edge.
- R9: Several enabled sources rising at the same edge produce a single one-cycle pulse.
- R10: A source falling, or being disabled while high, produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level | input | 4 | Level requests: bit 0 host, bit 1 statistics, bit 2 link, bit 3 access done |
| cfg_we | input | 1 | Write strobe for the enable register |
| cfg_wdata | input | 32 | Write data; enables at bits 4:1 |
| cfg_rdata | output | 32 | Read-back of the enable register |
| irq_pulse | output | 1 | Combined one-cycle interrupt pulse |

## Verification
A sequence of level patterns with all sources enabled tells apart a per-source edge detector from one that only looks at the OR of the sources. It covers:

- a lone rise
- a held level
- a second source joining one that is already high
- simultaneous rises
- falls
- re-rises

Directed cases then change the mask under active levels. These show that masked sources stay silent, that enabling a high source fires, and that disabling a high source does not. Register writes with every bit set show that only the four enable positions are stored.

// File: rtl/irq_pulse_merge.sv
module irq_pulse_merge #(
  parameter int NUM_SRC = 4,
  parameter int EN_LSB  = 1,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] src_level,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              irq_pulse
);
  localparam int EN_MSB = EN_LSB + NUM_SRC - 1;

  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] seen_q;
  logic               pulse_q;

  wire [NUM_SRC-1:0] live = src_level & en_q;
  wire [NUM_SRC-1:0] rise = live & ~seen_q;
  wire unused_wdata = ^{cfg_wdata[EN_LSB-1:0], cfg_wdata[DATA_W-1:EN_MSB+1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      seen_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (cfg_we) en_q <= cfg_wdata[EN_MSB:EN_LSB];
      seen_q  <= live;
      pulse_q <= |rise;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[EN_MSB:EN_LSB] = en_q;
  end

  assign irq_pulse = pulse_q;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!irq_pulse && cfg_rdata == '0));

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata[EN_MSB:EN_LSB] == $past(cfg_wdata[EN_MSB:EN_LSB]));

  assert_steady_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && $stable(src_level) && $stable(cfg_rdata) && !irq_pulse) |=> !irq_pulse);

  assert_masked_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_level & cfg_rdata[EN_MSB:EN_LSB]) == '0) |=> !irq_pulse);

  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> ($countones(cfg_rdata) <= NUM_SRC && !cfg_rdata[0]));
endmodule

// File: tb/irq_pulse_merge_tb.sv
module irq_pulse_merge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_level = 4'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq_pulse;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  irq_pulse_merge u_dut (
    .clk(clk), .rst_n(rst_n), .src_level(src_level), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_pulse(irq_pulse)
  );

  // {requirement number, level pattern, expected pulse}; all sources enabled
  localparam logic [8:0] VEC [14] = '{
    {4'd5, 4'b0000, 1'b0},
    {4'd4, 4'b0001, 1'b1},  // R4 lone rise
    {4'd5, 4'b0001, 1'b0},  // R5 held
    {4'd7, 4'b0011, 1'b1},  // R7 second source joins
    {4'd5, 4'b0011, 1'b0},
    {4'd10, 4'b0010, 1'b0}, // R10 fall
    {4'd10, 4'b0000, 1'b0},
    {4'd9, 4'b1100, 1'b1},  // R9 simultaneous rise
    {4'd9, 4'b1100, 1'b0},
    {4'd10, 4'b0000, 1'b0},
    {4'd4, 4'b0100, 1'b1},
    {4'd10, 4'b0000, 1'b0},
    {4'd4, 4'b0100, 1'b1},  // re-rise
    {4'd5, 4'b0000, 1'b0}
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] lv);
    @(negedge clk);
    src_level = lv;
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(posedge clk);
    #2;
    cfg_we = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset with sources high
    src_level = 4'b1111;
    repeat (3) @(posedge clk);
    #2;
    chk(1, {31'b0, irq_pulse}, 0);
    chk(1, cfg_rdata, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    chk(1, {31'b0, irq_pulse}, 0);
    step(4'b0000);
    // R2 / R3: write every bit, only enables stick
    wr(32'hFFFF_FFFF);
    chk(3, cfg_rdata, 32'h0000_001E);
    wr(32'h0000_0004);
    chk(2, cfg_rdata, 32'h0000_0004);
    wr(32'hFFFF_FFE1);
    chk(3, cfg_rdata, 32'h0);
    wr(32'h0000_001E);
    chk(2, cfg_rdata, 32'h0000_001E);
    for (int i = 0; i < 14; i++) begin
      step(VEC[i][4:1]);
      chk(int'(VEC[i][8:5]), {31'b0, irq_pulse}, {31'b0, VEC[i][0]});
    end
    // R6: only host enabled, others rise
    wr(32'h0000_0002);
    step(4'b1110);
    chk(6, {31'b0, irq_pulse}, 0);
    step(4'b1110);
    chk(6, {31'b0, irq_pulse}, 0);
    // R8: enable statistics (bit 2) while it is high
    wr(32'h0000_0004);
    chk(8, {31'b0, irq_pulse}, 0);
    step(4'b1110);
    chk(8, {31'b0, irq_pulse}, 1);
    step(4'b1110);
    chk(5, {31'b0, irq_pulse}, 0);
    // R10: disable while high, then no pulse
    wr(32'h0);
    step(4'b1110);
    chk(10, {31'b0, irq_pulse}, 0);
    // R8: enable link and access-done together while high -> single pulse
    wr(32'h0000_0018);
    step(4'b1110);
    chk(8, {31'b0, irq_pulse}, 1);
    step(4'b1110);
    chk(9, {31'b0, irq_pulse}, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule